// File: doc/BRIEF.md
# Shadowed Configuration Register Bank

This block stores the configuration words of a reconfigurable datapath. The configuration is split into one space per functional unit, and each space holds several fields. Every field has its own host address, so a host can change one setting of one unit without touching the others. The host bus is a simple memory-mapped port with a select line, a read-not-write line, an address, write data and read data.

The datapath never sees the host-written registers directly. A second register set, the shadow, drives the wide configuration bus. A one-cycle update strobe copies the whole main set into the shadow at once. The host can therefore prepare the next configuration while the datapath keeps running on the current one.

An internal store with a few slots can keep complete main configurations. A save command copies the main set into a slot, and a restore command copies a slot back into the main set. Each command works through the fields one at a time, one field per cycle. While a command runs, the bank shows that it is busy and ignores host writes.

Top module: `cfg_shadow_bank`

## Requirements
- R1: After reset, `cfg_bus_o` is zero, `busy_o` is low, every field reads back as zero, and every store slot restores all-zero fields.
- R2: A host write is a cycle with `sel_i`=1 and `rnw_i`=0. A write to field address k (k below the field count of 12) sets field k to `wdata_i[15:0]`. Bits 31:16 of the write data are ignored, and every other field keeps its value.
- R3: A read is a cycle with `sel_i`=1 and `rnw_i`=1. In the cycle after the read, `rdata_o` carries the main value of the addressed field, zero-extended to 32 bits. A read of any address that is neither a field nor a command returns zero.
- R4: Writing the main fields, saving them or restoring them leaves `cfg_bus_o` unchanged as long as `update_i` stays low.
- R5: In a cycle with `update_i`=1, the shadow takes the main value of every field. `cfg_bus_o[16*k +: 16]` then holds field k. Field k belongs to unit k/4 and is slot k%4 within that unit.
- R6: When `update_i` and a host write to the same field fall in the same cycle, the shadow takes the value the field held before that write, and the main field takes the new value.
- R7: A write to address 0x4000 saves the main fields into the slot given by `wdata_i[1:0]`. `busy_o` goes high in the next cycle and stays high for exactly 12 cycles.
- R8: A write to address 0x4001 restores the slot given by `wdata_i[1:0]` into the main fields over 12 busy cycles. The shadow and `cfg_bus_o` do not change until the next update.
- R9: While `busy_o` is high, host writes to fields and commands are ignored.
- R10: Each slot keeps its own contents. Saving to one slot leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Host access select |
| rnw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 15 | Field address or command address |
| wdata_i | input | 32 | Host write data: field value or slot index |
| rdata_o | output | 32 | Read data, valid in the cycle after a read |
| update_i | input | 1 | Copies the main fields into the shadow |
| busy_o | output | 1 | A save or restore is in progress |
| cfg_bus_o | output | 192 | Concatenated shadow fields driving the datapath |

## Verification
The assertions run on every cycle and check four things:
- the shadow holds its value whenever no update strobe arrives;
- the shadow loads the prior main values whenever an update strobe arrives;
- the main fields stay stable when no write port is active;
- a save or restore starts and ends the busy window as specified, and no host write or command gets past the block while it is busy.

Only the bench's scenarios can show the following:
- the field-to-bus-slice mapping;
- that a write really touches no neighbouring field;
- which value wins when an update and a write collide;
- that the data saved into a slot survives and comes back intact in the right slot.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_SAVE    = 2'd1,
    OP_RESTORE = 2'd2
  } store_op_e;
endpackage

// File: rtl/cfg_decode.sv
module cfg_decode
  import cfg_bank_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int N_FIELDS = 12,
  parameter int IDX_W    = 4,
  parameter int SLOT_W   = 2
) (
  input  logic              sel_i,
  input  logic              rnw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SLOT_W-1:0] slot_in_i,
  input  logic              busy_i,
  output logic              fld_we_o,
  output logic              rd_o,
  output logic              rd_hit_o,
  output logic [IDX_W-1:0]  fld_idx_o,
  output store_op_e         op_o,
  output logic [SLOT_W-1:0] slot_o
);
  localparam logic [ADDR_W-1:0] SAVE_ADDR    = {1'b1, {(ADDR_W-1){1'b0}}};
  localparam logic [ADDR_W-1:0] RESTORE_ADDR = SAVE_ADDR | ADDR_W'(1);

  logic hit, wr;

  always_comb begin
    hit       = addr_i < ADDR_W'(N_FIELDS);
    wr        = sel_i & ~rnw_i & ~busy_i;
    fld_we_o  = wr & hit;
    rd_o      = sel_i & rnw_i;
    rd_hit_o  = hit;
    fld_idx_o = addr_i[IDX_W-1:0];
    slot_o    = slot_in_i;
    op_o      = OP_IDLE;
    if (wr && addr_i == SAVE_ADDR)    op_o = OP_SAVE;
    if (wr && addr_i == RESTORE_ADDR) op_o = OP_RESTORE;
  end
endmodule

// File: rtl/cfg_main_regs.sv
module cfg_main_regs #(
  parameter int N_FIELDS = 12,
  parameter int FIELD_W  = 16,
  parameter int IDX_W    = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               we_i,
  input  logic [IDX_W-1:0]                   idx_i,
  input  logic [FIELD_W-1:0]                 wdata_i,
  input  logic                               rwe_i,
  input  logic [IDX_W-1:0]                   ridx_i,
  input  logic [FIELD_W-1:0]                 rdata_i,
  input  logic                               rd_i,
  input  logic                               rd_hit_i,
  output logic [N_FIELDS-1:0][FIELD_W-1:0]   main_o,
  output logic [FIELD_W-1:0]                 rdata_o
);
  logic [N_FIELDS-1:0][FIELD_W-1:0] main_q;
  logic [FIELD_W-1:0]               rdata_q;

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               main_q[g] <= '0;
      else if (rwe_i && ridx_i == IDX_W'(g))     main_q[g] <= rdata_i;
      else if (we_i && idx_i == IDX_W'(g))       main_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_hit_i ? main_q[idx_i] : '0;
  end

  assign main_o  = main_q;
  assign rdata_o = rdata_q;

  // R2
  main_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !rwe_i) |=> $stable(main_q));
endmodule

// File: rtl/cfg_shadow.sv
module cfg_shadow #(
  parameter int N_FIELDS = 12,
  parameter int FIELD_W  = 16
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             update_i,
  input  logic [N_FIELDS-1:0][FIELD_W-1:0] main_i,
  output logic [N_FIELDS*FIELD_W-1:0]      bus_o
);
  logic [N_FIELDS-1:0][FIELD_W-1:0] shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       shadow_q <= '0;
    else if (update_i) shadow_q <= main_i;
  end

  assign bus_o = shadow_q;

  // R4
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> $stable(bus_o));
  // R5
  shadow_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |=> (bus_o == $past(main_i)));
endmodule

// File: rtl/cfg_store.sv
module cfg_store
  import cfg_bank_pkg::*;
#(
  parameter int N_FIELDS = 12,
  parameter int FIELD_W  = 16,
  parameter int N_SLOTS  = 4,
  parameter int IDX_W    = 4,
  parameter int SLOT_W   = 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  store_op_e                        op_i,
  input  logic [SLOT_W-1:0]                slot_i,
  input  logic [N_FIELDS-1:0][FIELD_W-1:0] main_i,
  output logic                             busy_o,
  output logic                             rwe_o,
  output logic [IDX_W-1:0]                 ridx_o,
  output logic [FIELD_W-1:0]               rdata_o
);
  store_op_e          mode_q;
  logic [SLOT_W-1:0]  slot_q;
  logic [IDX_W-1:0]   idx_q;
  logic [FIELD_W-1:0] mem_q [N_SLOTS][N_FIELDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= OP_IDLE;
      slot_q <= '0;
      idx_q  <= '0;
      for (int s = 0; s < N_SLOTS; s++)
        for (int f = 0; f < N_FIELDS; f++) mem_q[s][f] <= '0;
    end else if (mode_q == OP_IDLE) begin
      if (op_i != OP_IDLE) begin
        mode_q <= op_i;
        slot_q <= slot_i;
        idx_q  <= '0;
      end
    end else begin
      if (mode_q == OP_SAVE) mem_q[slot_q][idx_q] <= main_i[idx_q];
      if (idx_q == IDX_W'(N_FIELDS - 1)) mode_q <= OP_IDLE;
      else                               idx_q  <= idx_q + 1'b1;
    end
  end

  assign busy_o  = mode_q != OP_IDLE;
  assign rwe_o   = mode_q == OP_RESTORE;
  assign ridx_o  = idx_q;
  assign rdata_o = mem_q[slot_q][idx_q];

  // R7
  store_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && op_i != OP_IDLE) |=> busy_o);
  // R7
  store_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(idx_q) == IDX_W'(N_FIELDS - 1)));
endmodule

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank
  import cfg_bank_pkg::*;
#(
  parameter int N_UNITS         = 3,
  parameter int FIELDS_PER_UNIT = 4,
  parameter int FIELD_W         = 16,
  parameter int N_SLOTS         = 4,
  parameter int ADDR_W          = 15,
  parameter int DATA_W          = 32,
  localparam int N_FIELDS       = N_UNITS * FIELDS_PER_UNIT,
  localparam int BUS_W          = N_FIELDS * FIELD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              rnw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              update_i,
  output logic              busy_o,
  output logic [BUS_W-1:0]  cfg_bus_o
);
  localparam int IDX_W  = $clog2(N_FIELDS);
  localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;

  logic                             fld_we, rd, rd_hit, rwe, busy;
  logic [IDX_W-1:0]                 fld_idx, ridx;
  logic [SLOT_W-1:0]                slot;
  logic [FIELD_W-1:0]               rest_data, rd_field;
  logic [N_FIELDS-1:0][FIELD_W-1:0] main;
  store_op_e                        op;
  logic                             unused_wbits;

  assign unused_wbits = ^wdata_i[DATA_W-1:FIELD_W];

  cfg_decode #(.ADDR_W(ADDR_W), .N_FIELDS(N_FIELDS), .IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_dec (
    .sel_i(sel_i), .rnw_i(rnw_i), .addr_i(addr_i), .slot_in_i(wdata_i[SLOT_W-1:0]),
    .busy_i(busy), .fld_we_o(fld_we), .rd_o(rd), .rd_hit_o(rd_hit),
    .fld_idx_o(fld_idx), .op_o(op), .slot_o(slot));

  cfg_main_regs #(.N_FIELDS(N_FIELDS), .FIELD_W(FIELD_W), .IDX_W(IDX_W)) u_main (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(fld_we), .idx_i(fld_idx),
    .wdata_i(wdata_i[FIELD_W-1:0]), .rwe_i(rwe), .ridx_i(ridx), .rdata_i(rest_data),
    .rd_i(rd), .rd_hit_i(rd_hit), .main_o(main), .rdata_o(rd_field));

  cfg_shadow #(.N_FIELDS(N_FIELDS), .FIELD_W(FIELD_W)) u_shadow (
    .clk_i(clk_i), .rst_ni(rst_ni), .update_i(update_i), .main_i(main), .bus_o(cfg_bus_o));

  cfg_store #(.N_FIELDS(N_FIELDS), .FIELD_W(FIELD_W), .N_SLOTS(N_SLOTS),
              .IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op), .slot_i(slot), .main_i(main),
    .busy_o(busy), .rwe_o(rwe), .ridx_o(ridx), .rdata_o(rest_data));

  assign rdata_o = DATA_W'(rd_field);
  assign busy_o  = busy;

  // R9
  host_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (!fld_we && op == OP_IDLE));
endmodule

// File: tb/cfg_shadow_bank_test.sv
`timescale 1ns/1ps
module cfg_shadow_bank_test;
  localparam int NF = 12;
  localparam logic [14:0] SAVE_A = 15'h4000;
  localparam logic [14:0] REST_A = 15'h4001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, rnw = 1'b1, update = 1'b0;
  logic [14:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic busy;
  logic [191:0] cfg_bus;

  always #2 clk = ~clk;

  cfg_shadow_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .rnw_i(rnw), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .update_i(update), .busy_o(busy),
    .cfg_bus_o(cfg_bus));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [15:0] m_main [NF];
  logic [15:0] m_shad [NF];
  logic [15:0] m_mem  [4][NF];

  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_pend = 1'b0;

  task automatic chk(input string tag, input logic [191:0] act, input logic [191:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [191:0] packed_shadow();
    logic [191:0] v;
    for (int k = 0; k < NF; k++) v[16*k +: 16] = m_shad[k];
    return v;
  endfunction

  // driver tasks: start and end at a falling edge
  task automatic host_write(input logic [14:0] a, input logic [31:0] d);
    sel = 1'b1; rnw = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; rnw = 1'b1;
  endtask

  task automatic host_read(input logic [14:0] a, input logic [31:0] exp, input string tag);
    sel = 1'b1; rnw = 1'b1; addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic write_field(input int k, input logic [31:0] d);
    host_write(15'(k), d);
    m_main[k] = d[15:0];
  endtask

  task automatic do_update();
    update = 1'b1;
    @(negedge clk);
    update = 1'b0;
    for (int k = 0; k < NF; k++) m_shad[k] = m_main[k];
  endtask

  task automatic read_all(input string tag);
    for (int k = 0; k < NF; k++) host_read(15'(k), {16'h0, m_main[k]}, tag);
  endtask

  task automatic wait_idle(output int cycles);
    cycles = 0;
    while (busy === 1'b1 && cycles < 100) begin
      cycles++;
      @(negedge clk);
    end
  endtask

  task automatic save_slot(input int s);
    int c;
    host_write(SAVE_A, 32'(s));
    wait_idle(c);
    for (int k = 0; k < NF; k++) m_mem[s][k] = m_main[k];
  endtask

  task automatic restore_slot(input int s);
    int c;
    host_write(REST_A, 32'(s));
    wait_idle(c);
    for (int k = 0; k < NF; k++) m_main[k] = m_mem[s][k];
  endtask

  // scoreboard monitor
  always @(posedge clk) rd_pend <= sel && rnw;
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) chk("scoreboard underflow", 192'd1, 192'd0);
      else chk(tag_q.pop_front(), {160'h0, rdata}, {160'h0, exp_q.pop_front()});
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int c;
    for (int k = 0; k < NF; k++) begin
      m_main[k] = '0; m_shad[k] = '0;
      for (int s = 0; s < 4; s++) m_mem[s][k] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 bus after reset", cfg_bus, 192'h0);
    chk("R1 busy after reset", {191'h0, busy}, 192'h0);
    read_all("R1 field after reset");

    // R2 / R3 field writes and reads
    for (int k = 0; k < NF; k++) write_field(k, 32'h5A00_0000 | 32'(16'h1000 + 16'(k * 273)));
    read_all("R2 field readback");
    write_field(5, 32'hFFFF_1234);
    read_all("R2 upper bits ignored, neighbours kept");
    host_read(15'h0100, 32'h0, "R3 unmapped read zero");
    host_read(15'h4000, 32'h0, "R3 command address read zero");

    // R4 bus untouched without update
    chk("R4 bus before update", cfg_bus, 192'h0);

    // R5 update copies all fields
    do_update();
    chk("R5 bus after update", cfg_bus, packed_shadow());

    // R6 update and write same field together
    sel = 1'b1; rnw = 1'b0; addr = 15'd3; wdata = 32'h0000_BEEF; update = 1'b1;
    @(negedge clk);
    sel = 1'b0; rnw = 1'b1; update = 1'b0;
    for (int k = 0; k < NF; k++) m_shad[k] = m_main[k];
    m_main[3] = 16'hBEEF;
    chk("R6 shadow keeps old value", cfg_bus, packed_shadow());
    host_read(15'd3, 32'h0000_BEEF, "R6 main takes new value");

    // R7 save timing
    host_write(SAVE_A, 32'd2);
    chk("R7 busy after save command", {191'h0, busy}, 192'h1);
    wait_idle(c);
    chk("R7 busy length", 192'(c), 192'(NF));
    for (int k = 0; k < NF; k++) m_mem[2][k] = m_main[k];

    // R9 writes ignored while busy
    host_write(SAVE_A, 32'd1);
    host_write(15'd0, 32'h0000_DEAD);
    host_write(REST_A, 32'd3);
    wait_idle(c);
    for (int k = 0; k < NF; k++) m_mem[1][k] = m_main[k];
    @(negedge clk);
    chk("R9 command ignored while busy", {191'h0, busy}, 192'h0);
    read_all("R9 field write ignored while busy");

    // change main, then restore slot 2
    for (int k = 0; k < NF; k++) write_field(k, 32'(16'h7000 + 16'(k)));
    chk("R4 bus after writes", cfg_bus, packed_shadow());
    restore_slot(2);
    read_all("R8 restored fields");
    chk("R8 bus unchanged after restore", cfg_bus, packed_shadow());
    do_update();
    chk("R5 bus after second update", cfg_bus, packed_shadow());

    // R10 slots independent; R1 unused slot is zero
    restore_slot(3);
    read_all("R1 R10 never-saved slot restores zero");
    restore_slot(1);
    read_all("R10 slot 1 contents");
    restore_slot(2);
    read_all("R10 slot 2 contents");

    repeat (3) @(negedge clk);
    chk("scoreboard drained", 192'(exp_q.size()), 192'h0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule